// File: doc/BRIEF.md
# Two-Wire Serial Target with Pointer-Selected Register Bank

This block is a target (slave) on a two-wire serial bus. Its clock and data lines are oversampled by the system clock. It gives the bus master read and write access to a small bank of 16-bit registers. A dedicated pointer byte picks which register is reached. The block passes both lines through a synchronizer, finds START, repeated START and STOP conditions, and moves bits and bytes in step with the master's clock. It answers only to its own 7-bit address. The upper four bits of that address are a fixed parameter and the lower three come from strap pins.

A write transaction carries the address byte and a pointer byte. It may then carry a high data byte and a low data byte, which together fill the selected register. The pointer is kept between transactions. A read therefore returns the register chosen by the most recent pointer, high byte first, for as long as the master keeps acknowledging. The data line is driven open-drain: `sda_oe` high pulls the line low.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, `sda_oe` is low and the pointer is 0. Register k holds 16'hA05A + 16'h0100*k, so the values are A05A, A15A, A25A and A35A.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A STOP releases SDA and returns the target to idle. A repeated START abandons the current transfer and restarts the address phase.
- R3: The first byte after a START is read MSB first. Bits 7..4 must equal ADDR_FIXED (default 4'b1001), bits 3..1 must equal `addr_pins`, and bit 0 is R/W (0 = write, 1 = read). On a match, the target pulls SDA low for the ninth clock.
- R4: On an address mismatch the target gives no acknowledge and ignores every later byte until the next START or STOP, so no register changes.
- R5: On a write, the byte after the address is the pointer byte. Its bits 1..0 select register 0..3, and it is acknowledged. A transaction that ends after the pointer byte changes no register.
- R6: In a write, the first data byte is the high byte and the second is the low byte. Both are acknowledged, and the selected register takes {high, low} once the low byte has been received.
- R7: A write that stops, or is cut by a repeated START, after only the high data byte leaves the register unchanged.
- R8: Data bytes after the second in one write are acknowledged and have no effect.
- R9: A read returns the selected register high byte then low byte, and repeats that same register while the master acknowledges. After the master's not-acknowledge the target keeps SDA released.
- R10: The target changes `sda_oe` only while SCL is low.
- R11: The pointer persists across transactions, and a read uses the most recently written pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire (wired-AND level) |
| addr_pins | input | 3 | Strap pins giving the low three address bits |
| sda_oe | output | 1 | High pulls the data line low; low releases it |

## Verification
Random register writes followed by pointer-setting reads with a repeated START exercise the word write path and the read path with many data patterns and pointer values. A stale pointer, a swapped byte order or a lost write each shows up as a mismatched word. Directed transfers separate the cases a random stream seldom hits. These are a pointer-only write, a write cut after its high byte by either a STOP or a repeated START, surplus data bytes, a four-byte read that must repeat the word, and a wrong address that must draw no acknowledge and leave the bank untouched. Changing the strap pins in the middle of the run shows that the address match follows the pins and that the previous address is then refused.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] reg_word_t;

    localparam reg_word_t REG_RESET_BASE = 16'hA05A;

    // Condition and edge events seen on the synchronized bus lines.
    typedef struct packed {
        logic scl;        // synchronized clock level
        logic sda;        // synchronized data level
        logic scl_rise;   // clock went low -> high
        logic scl_fall;   // clock went high -> low
        logic start;      // data fell with clock high
        logic stop;       // data rose with clock high
    } bus_evt_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RECV,       // shifting in a byte from the master
        ST_ACK_SETUP,  // byte taken, waiting for the clock to drop
        ST_ACK,        // holding SDA low through the ninth clock
        ST_SEND,       // shifting a byte out
        ST_SEND_END,   // last bit out, release on the next fall
        ST_MACK,       // master acknowledge slot
        ST_NEXT,       // master acked, load the next byte on the fall
        ST_IGNORE      // not selected or read ended: wait for START/STOP
    } tgt_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_PTR,
        BK_DATA
    } byte_kind_e;

    function automatic reg_word_t reg_reset_val(input int idx);
        return REG_RESET_BASE + reg_word_t'(idx * 256);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    // Index 1 carries the clock line, index 0 the data line.
    logic [1:0] chain [SYNC_STAGES];
    logic [1:0] prev_q;
    logic [1:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            chain[0] <= {scl_i, sda_i};
            for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            prev_q <= chain[SYNC_STAGES-1];
        end
    end

    assign cur = chain[SYNC_STAGES-1];

    always_comb begin
        evt.scl      = cur[1];
        evt.sda      = cur[0];
        evt.scl_rise = cur[1] & ~prev_q[1];
        evt.scl_fall = ~cur[1] & prev_q[1];
        evt.start    = cur[1] & prev_q[1] & prev_q[0] & ~cur[0];
        evt.stop     = cur[1] & prev_q[1] & ~prev_q[0] & cur[0];
    end

endmodule

// File: rtl/i2c_tgt_regbank.sv
module i2c_tgt_regbank
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int PTR_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             reg_we,
    input  reg_word_t        reg_wdata,
    output logic [PTR_W-1:0] ptr_q,
    output reg_word_t        rdata
);

    reg_word_t regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else if (ptr_we) ptr_q <= ptr_wdata;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) regs[g] <= reg_reset_val(g);
            else if (reg_we && ptr_q == PTR_W'(g)) regs[g] <= reg_wdata;
        end
    end

    assign rdata = regs[ptr_q];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] ADDR_FIXED = 4'b1001,
    parameter int         PTR_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic [2:0]       addr_pins,
    input  reg_word_t        rdata,
    output logic             sda_oe,
    output logic             ptr_we,
    output logic [PTR_W-1:0] ptr_wdata,
    output logic             reg_we,
    output reg_word_t        reg_wdata,
    output tgt_state_e       state_o
);

    tgt_state_e state;
    byte_kind_e kind;
    logic [2:0] bit_cnt;
    logic [6:0] rx_q;
    byte_t      tx_q;
    byte_t      hi_q;
    logic [1:0] wr_cnt;
    logic       rd_mode;
    logic       lo_next;

    byte_t rx_byte;
    byte_t next_tx;
    logic  drive_ok;

    assign rx_byte  = {rx_q, evt.sda};
    assign next_tx  = lo_next ? rdata[BYTE_W-1:0] : rdata[WORD_W-1:BYTE_W];
    assign drive_ok = evt.scl_fall & ~evt.scl;
    assign state_o  = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            kind      <= BK_ADDR;
            bit_cnt   <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            hi_q      <= '0;
            wr_cnt    <= '0;
            rd_mode   <= 1'b0;
            lo_next   <= 1'b0;
            sda_oe    <= 1'b0;
            ptr_we    <= 1'b0;
            ptr_wdata <= '0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            ptr_we <= 1'b0;
            reg_we <= 1'b0;
            if (evt.start) begin
                state   <= ST_RECV;
                kind    <= BK_ADDR;
                bit_cnt <= '0;
                rd_mode <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (evt.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_RECV: if (evt.scl_rise) begin
                        rx_q    <= rx_byte[6:0];
                        bit_cnt <= 3'(bit_cnt + 3'd1);
                        if (bit_cnt == 3'd7) begin
                            state <= ST_ACK_SETUP;
                            kind  <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
                            unique case (kind)
                                BK_ADDR: begin
                                    if (rx_byte[7:1] == {ADDR_FIXED, addr_pins})
                                        rd_mode <= rx_byte[0];
                                    else
                                        state <= ST_IGNORE;
                                end
                                BK_PTR: begin
                                    ptr_we    <= 1'b1;
                                    ptr_wdata <= rx_byte[PTR_W-1:0];
                                    wr_cnt    <= '0;
                                end
                                default: begin
                                    if (wr_cnt == 2'd0) begin
                                        hi_q <= rx_byte;
                                    end else if (wr_cnt == 2'd1) begin
                                        reg_we    <= 1'b1;
                                        reg_wdata <= {hi_q, rx_byte};
                                    end
                                    if (wr_cnt != 2'd2) wr_cnt <= 2'(wr_cnt + 2'd1);
                                end
                            endcase
                        end
                    end
                    ST_ACK_SETUP: if (drive_ok) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                    end
                    ST_ACK: if (drive_ok) begin
                        bit_cnt <= '0;
                        if (rd_mode) begin
                            tx_q    <= rdata[WORD_W-1:BYTE_W];
                            sda_oe  <= ~rdata[WORD_W-1];
                            lo_next <= 1'b1;
                            state   <= ST_SEND;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_RECV;
                        end
                    end
                    ST_SEND: begin
                        if (evt.scl_rise) begin
                            bit_cnt <= 3'(bit_cnt + 3'd1);
                            if (bit_cnt == 3'd7) state <= ST_SEND_END;
                        end else if (drive_ok) begin
                            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx_q[BYTE_W-2];
                        end
                    end
                    ST_SEND_END: if (drive_ok) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                    end
                    ST_MACK: if (evt.scl_rise) begin
                        state <= evt.sda ? ST_IGNORE : ST_NEXT;
                    end
                    ST_NEXT: if (drive_ok) begin
                        tx_q    <= next_tx;
                        sda_oe  <= ~next_tx[BYTE_W-1];
                        lo_next <= ~lo_next;
                        bit_cnt <= '0;
                        state   <= ST_SEND;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] ADDR_FIXED  = 4'b1001,
    parameter int         NUM_REGS    = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] addr_pins,
    output logic       sda_oe
);

    localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bus_evt_t         evt;
    tgt_state_e       state;
    logic             ptr_we;
    logic [PTR_W-1:0] ptr_wdata;
    logic [PTR_W-1:0] ptr_q;
    logic             reg_we;
    reg_word_t        reg_wdata;
    reg_word_t        rdata;

    i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_tgt_engine #(.ADDR_FIXED(ADDR_FIXED), .PTR_W(PTR_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .addr_pins (addr_pins),
        .rdata     (rdata),
        .sda_oe    (sda_oe),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .state_o   (state)
    );

    i2c_tgt_regbank #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .ptr_q     (ptr_q),
        .rdata     (rdata)
    );

endmodule

// File: rtl/i2c_ptr_target_chk.sv
module i2c_ptr_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             start_s,
    input logic             stop_s,
    input logic             sda_oe,
    input tgt_state_e       state,
    input logic             ptr_we,
    input logic [PTR_W-1:0] ptr_q
);

    // R10: the data line only moves while the clock is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    // R4: an unselected target stays off the line
    assert_ignore_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    // R2: STOP releases the line and idles
    assert_stop_release_R2: assert property (@(posedge clk) disable iff (rst)
        stop_s |=> (!sda_oe && state == ST_IDLE));

    // R2: START releases the line and enters the address phase
    assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
        start_s |=> (!sda_oe && state == ST_RECV));

    // R5 / R11: the pointer moves only on a pointer-byte capture
    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(ptr_q) |-> $past(ptr_we));

endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (evt.scl),
    .start_s (evt.start),
    .stop_s  (evt.stop),
    .sda_oe  (sda_oe),
    .state   (state),
    .ptr_we  (ptr_we),
    .ptr_q   (ptr_q)
);

// File: tb/i2c_ptr_target_tb.sv
module i2c_ptr_target_tb;

    localparam int         HALF    = 20;
    localparam logic [3:0] FIXED_A = 4'b1001;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [2:0] pins = 3'b101;
    logic       sda_oe;
    logic       sda_bus;

    always #4 clk = ~clk;   // 125 MHz

    assign sda_bus = m_sda & ~sda_oe;

    i2c_ptr_target u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .addr_pins (pins),
        .sda_oe    (sda_oe)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    int          r10_bad = 0;
    bit          done    = 1'b0;
    logic [15:0] model [4];
    logic        oe_prev = 1'b0;

    // R10 monitor: the target may only move SDA while SCL is low
    always @(negedge clk) begin
        if (!rst && sda_oe !== oe_prev && m_scl) r10_bad++;
        oe_prev = sda_oe;
    end

    function automatic logic [15:0] reset_word(input int k);
        return 16'hA05A + 16'(k * 256);
    endfunction

    function automatic logic [6:0] own_addr();
        return {FIXED_A, pins};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_sda = 1'b1; hold(HALF);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    hold(HALF);
        m_scl = 1'b1; hold(HALF);
        m_scl = 1'b0; hold(4);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; hold(HALF);
        m_scl = 1'b1; hold(HALF / 2);
        b = sda_bus;  hold(HALF / 2);
        m_scl = 1'b0; hold(4);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(!give_ack);
    endtask

    // Address byte then n payload bytes; returns number acknowledged.
    task automatic write_tx(input logic [6:0] a, input int n, input logic [7:0] bl [5],
                            input bit do_stop, output int acks);
        bit ak;
        acks = 0;
        bus_start();
        send_byte({a, 1'b0}, ak);
        if (ak) acks++;
        for (int i = 0; i < n; i++) begin
            send_byte(bl[i], ak);
            if (ak) acks++;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic read_n(input int n, output logic [31:0] got, output logic oe_after);
        bit ak;
        logic [7:0] b;
        got = '0;
        bus_start();
        send_byte({own_addr(), 1'b1}, ak);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            got = {got[23:0], b};
        end
        hold(HALF);
        oe_after = sda_oe;
        bus_stop();
    endtask

    task automatic write_word(input logic [1:0] p, input logic [15:0] d, output int acks);
        logic [7:0] bl [5];
        bl[0] = {6'd0, p}; bl[1] = d[15:8]; bl[2] = d[7:0]; bl[3] = '0; bl[4] = '0;
        write_tx(own_addr(), 3, bl, 1'b1, acks);
    endtask

    // Pointer write with no STOP, then a repeated START read of one word.
    task automatic ptr_read(input logic [1:0] p, output logic [15:0] w, output int acks);
        logic [7:0] bl [5];
        logic [31:0] got;
        logic oe_a;
        bl[0] = {6'd0, p}; bl[1] = '0; bl[2] = '0; bl[3] = '0; bl[4] = '0;
        write_tx(own_addr(), 1, bl, 1'b0, acks);
        read_n(2, got, oe_a);
        w = got[15:0];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  bl [5];
        logic [31:0] got;
        logic [15:0] w;
        logic        oe_a;
        int          acks;
        logic [1:0]  p;
        logic [15:0] d;
        logic [6:0]  old_a;

        void'($urandom(32'd2024));
        for (int k = 0; k < 4; k++) model[k] = reset_word(k);

        hold(10);
        rst = 1'b0;
        hold(10);

        // R1: reset state of the output and the bank
        check("R1 sda_oe after reset", {31'd0, sda_oe}, 32'd0);
        read_n(2, got, oe_a);
        check("R1 pointer 0 reads reg0 reset value", got, {16'd0, reset_word(0)});
        for (int k = 1; k < 4; k++) begin
            ptr_read(2'(k), w, acks);
            check("R1 reset value", {16'd0, w}, {16'd0, reset_word(k)});
        end

        // R6 / R9 / R11: random word writes, pointer-set repeated-START reads
        for (int it = 0; it < 12; it++) begin
            p = 2'($urandom % 4);
            d = 16'($urandom);
            write_word(p, d, acks);
            check("R6 word write acks", acks, 4);
            check("R2 SDA released after STOP", {31'd0, sda_oe}, 32'd0);
            model[p] = d;
            p = 2'($urandom % 4);
            ptr_read(p, w, acks);
            check("R11 read of pointed register", {16'd0, w}, {16'd0, model[p]});
        end

        // R9: four-byte read repeats the word, line released after NACK
        read_n(4, got, oe_a);
        check("R9 repeated word read", got, {model[p], model[p]});
        check("R9 released after NACK", {31'd0, oe_a}, 32'd0);

        // R4: mismatched address is not acknowledged and writes nothing
        bl[0] = 8'd2; bl[1] = 8'hDE; bl[2] = 8'hAD; bl[3] = '0; bl[4] = '0;
        write_tx(own_addr() ^ 7'h01, 3, bl, 1'b1, acks);
        check("R4 no ack on wrong address", acks, 0);
        ptr_read(2'd2, w, acks);
        check("R4 register untouched", {16'd0, w}, {16'd0, model[2]});

        // R5: pointer-only write moves the pointer, changes nothing
        bl[0] = 8'd1;
        write_tx(own_addr(), 1, bl, 1'b1, acks);
        check("R5 pointer-only acks", acks, 2);
        read_n(2, got, oe_a);
        check("R5 pointer-only leaves register", got, {16'd0, model[1]});

        // R7: only the high byte then STOP
        bl[0] = 8'd3; bl[1] = 8'h77;
        write_tx(own_addr(), 2, bl, 1'b1, acks);
        check("R7 partial write acks", acks, 3);
        read_n(2, got, oe_a);
        check("R7 partial write ignored", got, {16'd0, model[3]});

        // R2 / R7: high byte cut by a repeated START
        bl[0] = 8'd0; bl[1] = 8'h3C;
        write_tx(own_addr(), 2, bl, 1'b0, acks);
        read_n(2, got, oe_a);
        check("R2 repeated START read after cut write", got, {16'd0, model[0]});

        // R8: surplus data bytes acknowledged, no effect
        bl[0] = 8'd2; bl[1] = 8'h5A; bl[2] = 8'hC3; bl[3] = 8'h11; bl[4] = 8'h22;
        write_tx(own_addr(), 5, bl, 1'b1, acks);
        check("R8 surplus bytes acked", acks, 6);
        model[2] = 16'h5AC3;
        read_n(2, got, oe_a);
        check("R8 register holds first word only", got, {16'd0, model[2]});

        // R3: address follows the strap pins
        old_a = own_addr();
        pins = 3'b010;
        hold(10);
        bl[0] = 8'd1; bl[1] = 8'hBE; bl[2] = 8'hEF;
        write_tx(old_a, 3, bl, 1'b1, acks);
        check("R3 old address refused", acks, 0);
        write_word(2'd1, 16'h0F0F, acks);
        check("R3 new address accepted", acks, 4);
        model[1] = 16'h0F0F;
        read_n(2, got, oe_a);
        check("R3 R6 data via new address", got, {16'd0, model[1]});

        // R10: summary of the line-discipline monitor
        check("R10 SDA moved while SCL high", r10_bad, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule